// File: doc/BRIEF.md
# Three-Stage Clos Switch Fabric

This block steers single-bit signals from a set of input pins to a set of output pins through three layers of small crossbars. The ingress layer has R_EDGE switches of N_EDGE inputs by M_MID outputs. The center layer has M_MID switches of R_EDGE by R_EDGE. The egress layer mirrors the ingress layer, with R_EDGE switches of M_MID inputs by N_EDGE outputs. The links between the layers follow a fixed shuffle. The routing settings decide which center switch carries each connection. When M_MID is at least N_EDGE, any set of point-to-point connections can be placed.

Every crossbar output holds a stored select value and an enable bit. Software or a routing engine writes these one at a time through a configuration port. The port carries a stage code, a switch index, an output index, a select value and the enable bit. The data path itself is purely combinational from the stored settings. A combinational conflict output flags any stored setting that would fan a point-to-point net out, point outside a switch, or listen on a link that nothing drives.

Top module: `clos_fabric`

## Requirements
- R1: After reset, every crossbar output is disabled, so all output pins read 0 and conflict is low for any input pattern.
- R2: Pin p enters ingress switch p/N_EDGE at local input p%N_EDGE. Ingress switch i output k feeds center switch k input i. Center switch k output j feeds egress switch j input k. Egress switch j output b drives pin j*N_EDGE+b. Stage code 0 addresses ingress, 1 addresses center and 2 addresses egress. A write lands at the next clock edge, and data then propagates combinationally.
- R3: A crossbar output whose enable bit is clear drives 0.
- R4: A full permutation of the pins, placed with at most one connection per center switch from each ingress switch and to each egress switch, carries every pin at once with conflict low.
- R5: Writes are ignored when they carry stage code 3, a switch index at or above that stage's switch count, or an output index at or above that switch's output count.
- R6: Conflict rises while two enabled outputs of one switch select the same input.
- R7: Conflict rises while an enabled center output selects a link whose ingress output is disabled. It also rises while an enabled egress output selects a link whose center output is disabled.
- R8: An enabled output whose select value is at or above its switch's input count raises conflict and drives 0.
- R9: Writing an output with its enable bit clear removes that path. Conflict falls once no cause from R6 to R8 remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_stage | input | 2 | Stage code: 0 ingress, 1 center, 2 egress, 3 none |
| cfg_switch | input | SW_W | Switch index within the stage |
| cfg_out | input | IDX_W | Output index within the switch |
| cfg_sel | input | IDX_W | Input that the addressed output selects |
| cfg_valid | input | 1 | Enable bit written with the select |
| din | input | PINS | Input pins |
| dout | output | PINS | Output pins |
| conflict | output | 1 | Illegal stored setting present |

## Verification
The hardest states to reach are the conflict causes that a sensible routing never creates. Examples are a dangling link, where a center or egress output listens to a link that is disabled upstream, and a center output whose select points past its switch's inputs. The stimulus first builds a complete legal permutation. It then breaks that permutation one write at a time: it disables an ingress output under a live center route, then the center output, then the egress output. It watches the conflict flag and the affected pin at each step. The same base is used to plant a duplicate select and an out-of-range select, and then to restore each setting.

// File: rtl/clos_pkg.sv
package clos_pkg;

    typedef enum logic [1:0] {
        STG_INGRESS = 2'd0,
        STG_CENTER  = 2'd1,
        STG_EGRESS  = 2'd2,
        STG_SPARE   = 2'd3
    } stage_e;

    typedef struct packed {
        logic fanout;
        logic range;
    } xbar_flags_t;

    function automatic int idx_w(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/clos_xbar.sv
module clos_xbar
    import clos_pkg::*;
#(
    parameter int N_I   = 2,
    parameter int N_O   = 2,
    parameter int IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_out,
    input  logic [IDX_W-1:0]     wr_sel,
    input  logic                 wr_vld,
    input  logic [N_I-1:0]       din,
    output logic [N_O-1:0]       dout,
    output logic [N_O*IDX_W-1:0] sel_q,
    output logic [N_O-1:0]       vld_q,
    output xbar_flags_t          flags
);

    for (genvar o = 0; o < N_O; o++) begin : g_out
        logic [IDX_W-1:0] sel_r;
        logic             vld_r;
        logic             hit;

        always_ff @(posedge clk) begin
            if (rst) begin
                sel_r <= '0;
                vld_r <= 1'b0;
            end else if (wr_en && (wr_out == IDX_W'(o))) begin
                sel_r <= wr_sel;
                vld_r <= wr_vld;
            end
        end

        always_comb begin
            hit = 1'b0;
            for (int a = 0; a < N_I; a++) begin
                if (vld_r && (sel_r == IDX_W'(a))) begin
                    hit = din[a];
                end
            end
        end

        assign dout[o]                  = hit;
        assign sel_q[o*IDX_W +: IDX_W]  = sel_r;
        assign vld_q[o]                 = vld_r;
    end

    always_comb begin
        flags = '0;
        for (int o1 = 0; o1 < N_O; o1++) begin
            if (vld_q[o1] && (int'(sel_q[o1*IDX_W +: IDX_W]) >= N_I)) begin
                flags.range = 1'b1;
            end
            for (int o2 = o1 + 1; o2 < N_O; o2++) begin
                if (vld_q[o1] && vld_q[o2] &&
                    (sel_q[o1*IDX_W +: IDX_W] == sel_q[o2*IDX_W +: IDX_W])) begin
                    flags.fanout = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/clos_stage.sv
module clos_stage
    import clos_pkg::*;
#(
    parameter int COUNT = 3,
    parameter int N_I   = 2,
    parameter int N_O   = 2,
    parameter int IDX_W = 2,
    parameter int SW_W  = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [SW_W-1:0]            wr_sw,
    input  logic [IDX_W-1:0]           wr_out,
    input  logic [IDX_W-1:0]           wr_sel,
    input  logic                       wr_vld,
    input  logic [COUNT*N_I-1:0]       din,
    output logic [COUNT*N_O-1:0]       dout,
    output logic [COUNT*N_O*IDX_W-1:0] sel_q,
    output logic [COUNT*N_O-1:0]       vld_q,
    output logic                       bad
);

    logic [COUNT-1:0] bad_vec;

    for (genvar s = 0; s < COUNT; s++) begin : g_sw
        xbar_flags_t flg;

        clos_xbar #(
            .N_I   (N_I),
            .N_O   (N_O),
            .IDX_W (IDX_W)
        ) u_xbar (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_en && (wr_sw == SW_W'(s))),
            .wr_out (wr_out),
            .wr_sel (wr_sel),
            .wr_vld (wr_vld),
            .din    (din[s*N_I +: N_I]),
            .dout   (dout[s*N_O +: N_O]),
            .sel_q  (sel_q[s*N_O*IDX_W +: N_O*IDX_W]),
            .vld_q  (vld_q[s*N_O +: N_O]),
            .flags  (flg)
        );

        assign bad_vec[s] = flg.fanout | flg.range;
    end

    assign bad = |bad_vec;

endmodule

// File: rtl/clos_audit.sv
module clos_audit #(
    parameter int R_EDGE = 3,
    parameter int M_MID  = 2,
    parameter int N_EDGE = 2,
    parameter int IDX_W  = 2
) (
    input  logic [R_EDGE*M_MID-1:0]        s1_vld,
    input  logic [M_MID*R_EDGE*IDX_W-1:0]  s2_sel,
    input  logic [M_MID*R_EDGE-1:0]        s2_vld,
    input  logic [R_EDGE*N_EDGE*IDX_W-1:0] s3_sel,
    input  logic [R_EDGE*N_EDGE-1:0]       s3_vld,
    input  logic [2:0]                     stage_bad,
    output logic                           conflict
);

    logic dangle;

    always_comb begin
        dangle = 1'b0;
        for (int k = 0; k < M_MID; k++) begin
            for (int j = 0; j < R_EDGE; j++) begin
                for (int i = 0; i < R_EDGE; i++) begin
                    if (s2_vld[k*R_EDGE+j] &&
                        (s2_sel[(k*R_EDGE+j)*IDX_W +: IDX_W] == IDX_W'(i)) &&
                        !s1_vld[i*M_MID+k]) begin
                        dangle = 1'b1;
                    end
                end
            end
        end
        for (int j = 0; j < R_EDGE; j++) begin
            for (int b = 0; b < N_EDGE; b++) begin
                for (int k = 0; k < M_MID; k++) begin
                    if (s3_vld[j*N_EDGE+b] &&
                        (s3_sel[(j*N_EDGE+b)*IDX_W +: IDX_W] == IDX_W'(k)) &&
                        !s2_vld[k*R_EDGE+j]) begin
                        dangle = 1'b1;
                    end
                end
            end
        end
    end

    assign conflict = dangle | (|stage_bad);

endmodule

// File: rtl/clos_fabric.sv
module clos_fabric
    import clos_pkg::*;
#(
    parameter  int N_EDGE = 2,
    parameter  int M_MID  = 2,
    parameter  int R_EDGE = 3,
    localparam int PINS   = N_EDGE * R_EDGE,
    localparam int SW_W   = idx_w(max2(R_EDGE, M_MID)),
    localparam int IDX_W  = idx_w(max2(max2(N_EDGE, M_MID), R_EDGE))
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_stage,
    input  logic [SW_W-1:0]  cfg_switch,
    input  logic [IDX_W-1:0] cfg_out,
    input  logic [IDX_W-1:0] cfg_sel,
    input  logic             cfg_valid,
    input  logic [PINS-1:0]  din,
    output logic [PINS-1:0]  dout,
    output logic             conflict
);

    localparam int LINKS = R_EDGE * M_MID;

    stage_e stg;
    assign stg = stage_e'(cfg_stage);

    logic [LINKS-1:0]        s1_out, s2_in, s2_out, s3_in;
    logic [LINKS*IDX_W-1:0]  s1_sel_unused, s2_sel;
    logic [PINS*IDX_W-1:0]   s3_sel;
    logic [LINKS-1:0]        s1_vld, s2_vld;
    logic [PINS-1:0]         s3_vld;
    logic [2:0]              stage_bad;

    for (genvar i = 0; i < R_EDGE; i++) begin : g_up
        for (genvar k = 0; k < M_MID; k++) begin : g_mid
            assign s2_in[k*R_EDGE+i] = s1_out[i*M_MID+k];
        end
    end

    for (genvar k = 0; k < M_MID; k++) begin : g_dn
        for (genvar j = 0; j < R_EDGE; j++) begin : g_edge
            assign s3_in[j*M_MID+k] = s2_out[k*R_EDGE+j];
        end
    end

    clos_stage #(
        .COUNT (R_EDGE), .N_I (N_EDGE), .N_O (M_MID), .IDX_W (IDX_W), .SW_W (SW_W)
    ) u_ingress (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we && (stg == STG_INGRESS)),
        .wr_sw  (cfg_switch),
        .wr_out (cfg_out),
        .wr_sel (cfg_sel),
        .wr_vld (cfg_valid),
        .din    (din),
        .dout   (s1_out),
        .sel_q  (s1_sel_unused),
        .vld_q  (s1_vld),
        .bad    (stage_bad[0])
    );

    clos_stage #(
        .COUNT (M_MID), .N_I (R_EDGE), .N_O (R_EDGE), .IDX_W (IDX_W), .SW_W (SW_W)
    ) u_center (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we && (stg == STG_CENTER)),
        .wr_sw  (cfg_switch),
        .wr_out (cfg_out),
        .wr_sel (cfg_sel),
        .wr_vld (cfg_valid),
        .din    (s2_in),
        .dout   (s2_out),
        .sel_q  (s2_sel),
        .vld_q  (s2_vld),
        .bad    (stage_bad[1])
    );

    clos_stage #(
        .COUNT (R_EDGE), .N_I (M_MID), .N_O (N_EDGE), .IDX_W (IDX_W), .SW_W (SW_W)
    ) u_egress (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we && (stg == STG_EGRESS)),
        .wr_sw  (cfg_switch),
        .wr_out (cfg_out),
        .wr_sel (cfg_sel),
        .wr_vld (cfg_valid),
        .din    (s3_in),
        .dout   (dout),
        .sel_q  (s3_sel),
        .vld_q  (s3_vld),
        .bad    (stage_bad[2])
    );

    clos_audit #(
        .R_EDGE (R_EDGE), .M_MID (M_MID), .N_EDGE (N_EDGE), .IDX_W (IDX_W)
    ) u_audit (
        .s1_vld    (s1_vld),
        .s2_sel    (s2_sel),
        .s2_vld    (s2_vld),
        .s3_sel    (s3_sel),
        .s3_vld    (s3_vld),
        .stage_bad (stage_bad),
        .conflict  (conflict)
    );

endmodule

// File: rtl/clos_fabric_chk.sv
module clos_fabric_chk #(
    parameter int N_EDGE = 2,
    parameter int R_EDGE = 3
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cfg_we,
    input logic [1:0]               cfg_stage,
    input logic [N_EDGE*R_EDGE-1:0] din,
    input logic [N_EDGE*R_EDGE-1:0] dout,
    input logic                     conflict
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((dout == '0) && !conflict));

    p_no_invented_ones_r3: assert property (@(posedge clk) disable iff (rst)
        (din == '0) |-> (dout == '0));

    p_idle_keeps_flag_r5: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(conflict));

    p_spare_code_inert_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (cfg_stage == 2'd3)) |=> $stable(conflict));

    p_no_fanout_when_clean_r6: assert property (@(posedge clk) disable iff (rst)
        !conflict |-> ($countones(dout) <= $countones(din)));

endmodule

bind clos_fabric clos_fabric_chk #(
    .N_EDGE (N_EDGE),
    .R_EDGE (R_EDGE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_stage (cfg_stage),
    .din       (din),
    .dout      (dout),
    .conflict  (conflict)
);

// File: tb/test_clos_fabric.sv
module test_clos_fabric;

    localparam int CLK_PERIOD = 10;
    localparam int N = 2;
    localparam int R = 3;
    localparam int PINS = N * R;
    localparam int NVEC = 10;

    // {din, expected dout} for the fixed permutation built below
    localparam logic [11:0] VEC [NVEC] = '{
        {6'b000001, 6'b000100},
        {6'b000010, 6'b010000},
        {6'b000100, 6'b000010},
        {6'b001000, 6'b100000},
        {6'b010000, 6'b001000},
        {6'b100000, 6'b000001},
        {6'b111111, 6'b111111},
        {6'b101010, 6'b110001},
        {6'b010101, 6'b001110},
        {6'b000000, 6'b000000}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_stage = '0;
    logic [1:0]      cfg_switch = '0;
    logic [1:0]      cfg_out = '0;
    logic [1:0]      cfg_sel = '0;
    logic            cfg_valid = 1'b0;
    logic [PINS-1:0] din = '0;
    logic [PINS-1:0] dout;
    logic            conflict;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clos_fabric i_clos_fabric (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_stage  (cfg_stage),
        .cfg_switch (cfg_switch),
        .cfg_out    (cfg_out),
        .cfg_sel    (cfg_sel),
        .cfg_valid  (cfg_valid),
        .din        (din),
        .dout       (dout),
        .conflict   (conflict)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input int stg, input int sw, input int o, input int sel, input logic vld);
        @(negedge clk);
        cfg_stage  = 2'(stg);
        cfg_switch = 2'(sw);
        cfg_out    = 2'(o);
        cfg_sel    = 2'(sel);
        cfg_valid  = vld;
        cfg_we     = 1'b1;
        @(negedge clk);
        cfg_we     = 1'b0;
    endtask

    task automatic route(input int src, input int mid, input int dst);
        cfg(0, src / N, mid, src % N, 1'b1);
        cfg(1, mid, dst / N, src / N, 1'b1);
        cfg(2, dst / N, dst % N, mid, 1'b1);
    endtask

    task automatic apply(input logic [PINS-1:0] v);
        din = v;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        tests++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        apply('1);
        check("R1 dout in reset", 32'(dout), 32'h0);
        check("R1 conflict in reset", 32'(conflict), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        apply('1);
        check("R1 dout after reset", 32'(dout), 32'h0);

        // single path pin0 -> center 0 -> pin3
        route(0, 0, 3);
        apply(6'b000001);
        check("R2 single path", 32'(dout), 32'b001000);
        apply(6'b111110);
        check("R3 disabled outputs drive 0", 32'(dout), 32'h0);
        check("R2 single path conflict", 32'(conflict), 32'h0);

        // full permutation
        do_reset();
        route(5, 0, 0);
        route(2, 1, 1);
        route(0, 0, 2);
        route(4, 1, 3);
        route(1, 1, 4);
        route(3, 0, 5);
        check("R4 permutation conflict", 32'(conflict), 32'h0);
        for (int v = 0; v < NVEC; v++) begin
            apply(VEC[v][11:6]);
            check($sformatf("R4 vector %0d", v), 32'(dout), 32'(VEC[v][5:0]));
        end

        // ignored writes
        cfg(3, 0, 0, 0, 1'b0);
        cfg(0, 3, 0, 1, 1'b1);
        cfg(0, 0, 2, 1, 1'b1);
        apply(6'b101010);
        check("R5 ignored writes dout", 32'(dout), 32'b110001);
        apply(6'b010101);
        check("R5 ignored writes dout b", 32'(dout), 32'b001110);
        check("R5 ignored writes conflict", 32'(conflict), 32'h0);

        // fanout in center switch 0
        cfg(1, 0, 2, 2, 1'b1);
        check("R6 fanout conflict", 32'(conflict), 32'h1);
        cfg(1, 0, 2, 1, 1'b1);
        check("R6 fanout restored", 32'(conflict), 32'h0);

        // out-of-range select
        cfg(1, 0, 0, 3, 1'b1);
        check("R8 range conflict", 32'(conflict), 32'h1);
        apply('1);
        check("R8 range output zero", 32'(dout), 32'b111110);
        cfg(1, 0, 0, 2, 1'b1);
        check("R8 range restored", 32'(conflict), 32'h0);

        // dangling links, torn down from the ingress side
        cfg(0, 2, 0, 0, 1'b0);
        check("R7 dangling center", 32'(conflict), 32'h1);
        apply('1);
        check("R7 dangling path output", 32'(dout), 32'b111110);
        cfg(1, 0, 0, 2, 1'b0);
        check("R7 dangling egress", 32'(conflict), 32'h1);
        cfg(2, 0, 0, 0, 1'b0);
        check("R9 teardown clears conflict", 32'(conflict), 32'h0);
        apply('1);
        check("R9 teardown dout", 32'(dout), 32'b111110);

        finish_run();
    end

endmodule